// File: doc/BRIEF.md
# Output On/Off Delay Stage

This block conditions a single logic result before it becomes a final output. A rising change of the raw result passes to the output only after the raw value has stayed high for the on-delay preset. A falling change passes only after the raw value has stayed low for the off-delay preset. Both presets are counted in clock-enable ticks, so one design serves any tick rate chosen by the surrounding logic.

While a delay is running, the block reports how far it has progressed as an integer percentage. An enable input and an initialize request both force the output low and clear the timer. A preset above the valid limit raises a configuration error flag. The timer then uses the limit value in place of the out-of-range preset.

Top module: `out_delay_stage`

## Requirements
- R1: After reset the output is 0, the percent value is 0 and the timer is clear.
- R2: With an on-delay preset N > 0, the output goes to 1 at the clock edge that carries the N-th tick during which the raw input has been 1 while the output was 0.
- R3: With an off-delay preset N > 0, the output goes to 0 at the clock edge that carries the N-th tick during which the raw input has been 0 while the output was 1.
- R4: A preset of 0 in the active direction copies the raw value to the output at the next clock edge, whether or not a tick is present.
- R5: If the raw input returns to the current output value before the delay expires, the elapsed count restarts from zero and the output does not change.
- R6: Clock cycles without a tick do not advance a running delay.
- R7: The percent output equals floor(elapsed_ticks × 100 / active_preset) while a delay is running, saturates at 100, and reads 0 when no delay is running.
- R8: When the enable is 0, the output is cleared and the timer is reset at the next clock edge, and the percent output reads 0.
- R9: An initialize request clears the output and the timer in the same way as a low enable.
- R10: The preset error flag is 1 in the same cycle in which either preset is greater than 2147483 × TICKS_PER_SEC (default 1000, which gives a limit of 2147483000), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for the delay count |
| en_i | input | 1 | Stage enable; 0 clears output and timer |
| init_i | input | 1 | Initialize request; clears output and timer |
| raw_i | input | 1 | Raw logic result to be delayed |
| on_preset_i | input | 32 | On-delay preset in ticks |
| off_preset_i | input | 32 | Off-delay preset in ticks |
| out_o | output | 1 | Delayed output |
| pct_o | output | 8 | Percent complete of the running delay |
| preset_err_o | output | 1 | Preset out-of-range flag |

## Verification
A corrupted elapsed count shows up on the ports in two ways. The percent output shows it in the same cycle. The output then toggles one or more ticks away from the expected edge. An output register stuck at the wrong value flips the delay direction at once: the wrong preset is selected, and the percent value goes nonzero while the raw input matches the output. A clear path that fails leaves out_o high for one edge after enable drops. The scoreboard catches this at the first sample after that edge.

// File: rtl/delay_pkg.sv
package delay_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned PCT_W = 8;
  localparam int unsigned PCT_FULL = 100;
  localparam longint unsigned SEC_LIMIT = 64'd2147483;
endpackage

// File: rtl/preset_check.sv
module preset_check
  import delay_pkg::*;
#(
  parameter longint unsigned TICKS_PER_SEC = 1000
) (
  input  logic [CNT_W-1:0] on_raw_i,
  input  logic [CNT_W-1:0] off_raw_i,
  output logic [CNT_W-1:0] on_eff_o,
  output logic [CNT_W-1:0] off_eff_o,
  output logic             err_o
);
  localparam longint unsigned LIMIT_L = SEC_LIMIT * TICKS_PER_SEC;
  localparam longint unsigned CAP_L   = (LIMIT_L > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : LIMIT_L;
  localparam logic [CNT_W-1:0] LIMIT  = CAP_L[CNT_W-1:0];

  logic on_bad, off_bad;

  always_comb begin
    on_bad    = on_raw_i > LIMIT;
    off_bad   = off_raw_i > LIMIT;
    on_eff_o  = on_bad ? LIMIT : on_raw_i;
    off_eff_o = off_bad ? LIMIT : off_raw_i;
    err_o     = on_bad | off_bad;
  end

  always_comb begin
    p_eff_in_range_r10: assert (on_eff_o <= LIMIT && off_eff_o <= LIMIT);
  end
endmodule

// File: rtl/delay_counter.sv
module delay_counter
  import delay_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] on_ticks_i,
  input  logic [CNT_W-1:0] off_ticks_i,
  output logic             out_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             active_o
);
  logic             out_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sel;
  logic             differ;

  always_comb begin
    sel      = out_q ? off_ticks_i : on_ticks_i;
    differ   = raw_i ^ out_q;
    active_o = !clr_i && differ && (sel != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (sel == '0) begin
      out_q <= raw_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == sel - 1'b1) begin
        out_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o     = out_q;
  assign elapsed_o = cnt_q;
  assign preset_o  = sel;

  p_rise_follows_raw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> $past(raw_i && !clr_i));
  p_fall_follows_raw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> $past(!raw_i || clr_i));
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !differ) |=> (cnt_q == '0) && $stable(out_q));
  p_no_tick_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && active_o) |=> $stable(out_q) && $stable(cnt_q));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !out_q && (cnt_q == '0));
endmodule

// File: rtl/pct_calc.sv
module pct_calc
  import delay_pkg::*;
(
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             active_i,
  output logic [PCT_W-1:0] pct_o
);
  localparam int unsigned PROD_W = CNT_W + 7;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    prod = PROD_W'(elapsed_i) * PROD_W'(PCT_FULL);
    quot = (preset_i != '0) ? prod / PROD_W'(preset_i) : '0;
    if (!active_i)                    pct_o = '0;
    else if (quot > PROD_W'(PCT_FULL)) pct_o = PCT_W'(PCT_FULL);
    else                              pct_o = quot[PCT_W-1:0];
  end

  always_comb begin
    p_pct_bound_r7: assert (pct_o <= PCT_W'(PCT_FULL));
  end
endmodule

// File: rtl/out_delay_stage.sv
module out_delay_stage
  import delay_pkg::*;
#(
  parameter longint unsigned TICKS_PER_SEC = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             init_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] on_preset_i,
  input  logic [CNT_W-1:0] off_preset_i,
  output logic             out_o,
  output logic [PCT_W-1:0] pct_o,
  output logic             preset_err_o
);
  logic [CNT_W-1:0] on_eff, off_eff, elapsed, preset_sel;
  logic             active, clr;

  assign clr = !en_i || init_i;

  preset_check #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
    .on_raw_i (on_preset_i),
    .off_raw_i(off_preset_i),
    .on_eff_o (on_eff),
    .off_eff_o(off_eff),
    .err_o    (preset_err_o)
  );

  delay_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .clr_i      (clr),
    .raw_i      (raw_i),
    .on_ticks_i (on_eff),
    .off_ticks_i(off_eff),
    .out_o      (out_o),
    .elapsed_o  (elapsed),
    .preset_o   (preset_sel),
    .active_o   (active)
  );

  pct_calc u_pct (
    .elapsed_i(elapsed),
    .preset_i (preset_sel),
    .active_i (active),
    .pct_o    (pct_o)
  );

  p_zero_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i && (raw_i != out_o) && (preset_sel == '0)) |=> (out_o == $past(raw_i)));
  p_idle_pct_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == out_o) |-> (pct_o == '0));
  p_init_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !out_o);
endmodule

// File: tb/sim_out_delay_stage.sv
module sim_out_delay_stage;
  localparam longint unsigned TPS   = 1000;
  localparam longint unsigned LIMIT = 64'd2147483 * TPS;

  typedef struct {
    logic  out;
    int    pct;
    logic  err;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, en_i = 1'b0, init_i = 1'b0, raw_i = 1'b0;
  logic [31:0] on_preset_i = '0, off_preset_i = '0;
  logic        out_o, preset_err_o;
  logic [7:0]  pct_o;

  int   checks = 0, fails = 0;
  bit   done = 0;
  exp_t sb[$];

  logic            m_out = 1'b0;
  longint unsigned m_cnt = 0;

  always #2 clk_i = ~clk_i;

  out_delay_stage #(.TICKS_PER_SEC(TPS)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .init_i(init_i), .raw_i(raw_i), .on_preset_i(on_preset_i),
    .off_preset_i(off_preset_i), .out_o(out_o), .pct_o(pct_o),
    .preset_err_o(preset_err_o)
  );

  function automatic longint unsigned eff(input logic [31:0] p);
    return (longint'(p) > LIMIT) ? LIMIT : longint'(p);
  endfunction

  task automatic step(input logic raw, input logic tick, input logic en,
                      input logic init, input string tag);
    exp_t e;
    longint unsigned pe;
    bit clr;
    @(negedge clk_i);
    raw_i = raw; tick_i = tick; en_i = en; init_i = init;
    clr = !en || init;
    pe  = m_out ? eff(off_preset_i) : eff(on_preset_i);
    if (clr) begin
      m_out = 1'b0; m_cnt = 0;
    end else if (raw == m_out) begin
      m_cnt = 0;
    end else if (pe == 0) begin
      m_out = raw; m_cnt = 0;
    end else if (tick) begin
      if (m_cnt + 1 >= pe) begin m_out = raw; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    pe = m_out ? eff(off_preset_i) : eff(on_preset_i);
    e.out = m_out;
    if (!clr && raw != m_out && pe != 0)
      e.pct = ((m_cnt * 100) / pe > 100) ? 100 : int'((m_cnt * 100) / pe);
    else
      e.pct = 0;
    e.err = (longint'(on_preset_i) > LIMIT) || (longint'(off_preset_i) > LIMIT);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic presets(input logic [31:0] on_v, input logic [31:0] off_v);
    @(negedge clk_i);
    on_preset_i = on_v; off_preset_i = off_v;
  endtask

  always @(posedge clk_i) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out_o !== e.out || int'(pct_o) != e.pct || preset_err_o !== e.err) begin
        fails++;
        $display("FAIL %s: out=%b pct=%0d err=%b expected out=%b pct=%0d err=%b",
                 e.tag, out_o, pct_o, preset_err_o, e.out, e.pct, e.err);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (out_o !== 1'b0 || pct_o !== 8'd0) begin
      fails++;
      $display("FAIL R1: out=%b pct=%0d expected out=0 pct=0", out_o, pct_o);
    end
    rst_ni = 1'b1;
    step(0, 1, 1, 0, "R1");

    // R4: zero presets pass straight through, even without a tick
    step(1, 0, 1, 0, "R4");
    step(0, 0, 1, 0, "R4");

    // R2: on-delay of 4 ticks, R7 percent 25/50/75
    presets(32'd4, 32'd3);
    for (int i = 0; i < 5; i++) step(1, 1, 1, 0, "R2");
    // R3: off-delay of 3 ticks, R7 percent 33/66
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, "R3");

    // R6: ticks on every other cycle
    for (int i = 0; i < 10; i++) step(1, i[0], 1, 0, "R6");

    // R5: raw drops back before off-delay expires, then full off-delay
    step(0, 1, 1, 0, "R5");
    step(0, 1, 1, 0, "R5");
    step(1, 1, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, "R5");

    // R7: odd preset gives truncated percent values
    presets(32'd7, 32'd7);
    for (int i = 0; i < 8; i++) step(1, 1, 1, 0, "R7");

    // R8: enable low clears output and timer
    step(1, 1, 0, 0, "R8");
    step(1, 1, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, "R8");

    // R9: initialize request mid-delay and on a high output
    step(1, 1, 1, 1, "R9");
    for (int i = 0; i < 8; i++) step(1, 1, 1, 0, "R9");
    step(1, 1, 1, 1, "R9");
    step(0, 1, 1, 0, "R9");

    // R10: preset range check at and past the limit
    presets(32'd2147483000, 32'd5);
    step(0, 1, 1, 0, "R10");
    presets(32'd2147483001, 32'd5);
    step(0, 1, 1, 0, "R10");
    presets(32'd5, 32'hFFFF_FFFF);
    step(0, 1, 1, 0, "R10");
    presets(32'd0, 32'd0);
    step(0, 1, 1, 0, "R10");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule